// File: doc/BRIEF.md
# Memory-Mapped 32x32 Multiply Coprocessor

This block gives a small processor core that lacks a multiply instruction a way to form full-width products over its ordinary register bus. Software writes the first factor, then writes the second factor. Writing the second factor starts the operation. Software then polls a status word until the busy flag drops, and reads the 64-bit result as two 32-bit words, low half first and high half second.

The product comes from a purely combinational partial-product array that has no internal registers. Because the operand registers are frozen while an operation runs, and the array output is captured only once, at the end of a fixed window of clock cycles, the array can be constrained as a multicycle path. A mode bit chooses between an unsigned product and a two's-complement product. In signed mode the high word is the correctly signed upper half. The full 64-bit result comes from the same hardware with the same latency as a 32-bit result would.

Top module: `mmul_periph`

## Requirements
- R1: While `rst` is high, and afterwards until written, every readable location reads as zero: factor A at offset 0, factor B at offset 1, product low word at offset 2, product high word at offset 3, and the control/status word at offset 4.
- R2: A bus write (`bus_en`=1, `bus_we`=1) to offset 0 or offset 1 while idle stores `bus_wdata` into factor A or factor B. Reading the same offset then returns the stored value.
- R3: A write to offset 1 while idle starts an operation. The busy flag (bit 1 of offset 4) reads 1 for exactly 3 cycles after that write's clock edge. It drops on the edge that loads the product registers.
- R4: With the mode bit (bit 0 of offset 4) at 0, offsets 2 and 3 hold the low and high 32 bits of the unsigned 64-bit product A*B.
- R5: With the mode bit at 1, offsets 2 and 3 hold the low and high 32 bits of the two's-complement 64-bit product A*B.
- R6: While busy, writes to offsets 0, 1 and 4 are ignored. The factors and the mode bit keep their values, and the operation is neither restarted nor lengthened.
- R7: The done flag (bit 2 of offset 4) rises on the edge that loads the product. It stays set through reads of other offsets. The first read of offset 3 clears it, and it is also cleared when a new operation starts.
- R8: Writes to offsets 2, 3 and 5 to 7 change nothing. Offsets 5 to 7 and bits 31:3 of offset 4 always read as zero.
- R9: The product registers keep their value until the next operation completes. Idle cycles, reads and factor writes do not change them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 3 | Word offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |

## Verification
The hardest situations to reach from the ports are bus traffic that lands inside the three-cycle busy window, and a high-word read that falls on the same edge as the product load. From the outside these look like ordinary accesses. The stimulus issues writes to the factor and control registers on every cycle of the window. It also issues streams of randomly chosen accesses that start operations back to back, so that high-word reads and rejected writes fall on every phase of the window. A behavioural reference model that keeps a cycle countdown is compared with the read data on every clock, and directed corner products cover the sign handling.

// File: rtl/mmul_pkg.sv
package mmul_pkg;

    localparam int unsigned REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        REG_FAC_A   = 3'd0,
        REG_FAC_B   = 3'd1,
        REG_PROD_LO = 3'd2,
        REG_PROD_HI = 3'd3,
        REG_CSR     = 3'd4
    } reg_sel_e;

    localparam int unsigned CSR_MODE_BIT = 0;
    localparam int unsigned CSR_BUSY_BIT = 1;
    localparam int unsigned CSR_DONE_BIT = 2;

    typedef struct packed {
        logic wr_a;
        logic wr_b;
        logic wr_mode;
        logic rd_hi;
    } bus_dec_t;

    typedef struct packed {
        logic mode_signed;
        logic busy;
        logic done;
    } stat_t;

    function automatic bus_dec_t decode_access(input logic en, input logic we,
                                               input logic [REG_AW-1:0] addr,
                                               input logic busy);
        bus_dec_t d;
        d.wr_a    = en && we && !busy && (reg_sel_e'(addr) == REG_FAC_A);
        d.wr_b    = en && we && !busy && (reg_sel_e'(addr) == REG_FAC_B);
        d.wr_mode = en && we && !busy && (reg_sel_e'(addr) == REG_CSR);
        d.rd_hi   = en && !we && (reg_sel_e'(addr) == REG_PROD_HI);
        return d;
    endfunction

endpackage

// File: rtl/mmul_opregs.sv
module mmul_opregs
    import mmul_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_en,
    input  logic                  bus_we,
    input  logic [REG_AW-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  busy,
    output logic [DATA_W-1:0]     fac_a,
    output logic [DATA_W-1:0]     fac_b,
    output logic                  mode_signed,
    output logic                  start,
    output logic                  rd_hi
);

    bus_dec_t dec;

    always_comb begin
        dec   = decode_access(bus_en, bus_we, bus_addr, busy);
        start = dec.wr_b;
        rd_hi = dec.rd_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fac_a       <= '0;
            fac_b       <= '0;
            mode_signed <= 1'b0;
        end else begin
            if (dec.wr_a)    fac_a       <= bus_wdata;
            if (dec.wr_b)    fac_b       <= bus_wdata;
            if (dec.wr_mode) mode_signed <= bus_wdata[CSR_MODE_BIT];
        end
    end

    // R6
    fac_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(fac_a) && $stable(fac_b) && $stable(mode_signed)));

endmodule

// File: rtl/mmul_sequencer.sv
module mmul_sequencer #(
    parameter int unsigned LAT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic rd_hi,
    output logic busy,
    output logic done,
    output logic load
);

    localparam int unsigned CW = $clog2(LAT + 1);

    logic [CW-1:0] remain;

    assign load = busy && (remain == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy   <= 1'b0;
            done   <= 1'b0;
            remain <= '0;
        end else begin
            if (start) begin
                busy   <= 1'b1;
                remain <= CW'(LAT - 1);
            end else if (load) begin
                busy   <= 1'b0;
            end else if (busy) begin
                remain <= remain - 1'b1;
            end

            if (start)      done <= 1'b0;
            else if (load)  done <= 1'b1;
            else if (rd_hi) done <= 1'b0;
        end
    end

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !load) |=> busy);

    // R7
    done_on_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (done && !busy));

    // R7
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_hi && !load && !start) |=> !done);

endmodule

// File: rtl/mmul_array.sv
module mmul_array #(
    parameter int unsigned DATA_W = 32
) (
    input  logic [DATA_W-1:0]   fac_a,
    input  logic [DATA_W-1:0]   fac_b,
    input  logic                mode_signed,
    output logic [2*DATA_W-1:0] prod
);

    localparam int unsigned PW = 2 * DATA_W;

    logic [PW-1:0] a_ext;
    logic [PW-1:0] rows [DATA_W];
    logic [PW-1:0] corr;

    assign a_ext = mode_signed ? {{DATA_W{fac_a[DATA_W-1]}}, fac_a}
                               : {{DATA_W{1'b0}}, fac_a};

    for (genvar i = 0; i < DATA_W; i++) begin : g_row
        assign rows[i] = fac_b[i] ? (a_ext << i) : '0;
    end

    // A negative multiplier weighs its top bit as -2^(DATA_W-1): subtract a 2^DATA_W shift.
    assign corr = (mode_signed && fac_b[DATA_W-1]) ? (PW'(0) - (a_ext << DATA_W)) : '0;

    always_comb begin
        prod = corr;
        for (int k = 0; k < DATA_W; k++) begin
            prod = prod + rows[k];
        end
    end

endmodule

// File: rtl/mmul_periph.sv
module mmul_periph
    import mmul_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LAT    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_en,
    input  logic                bus_we,
    input  logic [REG_AW-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata
);

    localparam int unsigned PW = 2 * DATA_W;

    logic [DATA_W-1:0] fac_a;
    logic [DATA_W-1:0] fac_b;
    logic              start;
    logic              rd_hi;
    logic              load;
    logic [PW-1:0]     prod_comb;
    logic [PW-1:0]     prod_q;
    stat_t             st;

    mmul_opregs #(.DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_en      (bus_en),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .busy        (st.busy),
        .fac_a       (fac_a),
        .fac_b       (fac_b),
        .mode_signed (st.mode_signed),
        .start       (start),
        .rd_hi       (rd_hi)
    );

    mmul_sequencer #(.LAT(LAT)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .rd_hi (rd_hi),
        .busy  (st.busy),
        .done  (st.done),
        .load  (load)
    );

    mmul_array #(.DATA_W(DATA_W)) u_array (
        .fac_a       (fac_a),
        .fac_b       (fac_b),
        .mode_signed (st.mode_signed),
        .prod        (prod_comb)
    );

    always_ff @(posedge clk) begin
        if (rst)       prod_q <= '0;
        else if (load) prod_q <= prod_comb;
    end

    always_comb begin
        bus_rdata = '0;
        case (reg_sel_e'(bus_addr))
            REG_FAC_A:   bus_rdata = fac_a;
            REG_FAC_B:   bus_rdata = fac_b;
            REG_PROD_LO: bus_rdata = prod_q[DATA_W-1:0];
            REG_PROD_HI: bus_rdata = prod_q[PW-1:DATA_W];
            REG_CSR: begin
                bus_rdata[CSR_MODE_BIT] = st.mode_signed;
                bus_rdata[CSR_BUSY_BIT] = st.busy;
                bus_rdata[CSR_DONE_BIT] = st.done;
            end
            default:     bus_rdata = '0;
        endcase
    end

    // R9
    prod_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(prod_q));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (prod_q == '0 && !st.busy && !st.done && fac_a == '0 && fac_b == '0));

    // R8
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > 3'd4) |-> (bus_rdata == '0));

endmodule

// File: tb/mmul_periph_tb.sv
`timescale 1ns/1ps
module mmul_periph_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wd = '0;
    logic [31:0] rdata;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    mmul_periph u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_en    (en),
        .bus_we    (we),
        .bus_addr  (addr),
        .bus_wdata (wd),
        .bus_rdata (rdata)
    );

    // Behavioural reference model
    logic [31:0] m_a = '0, m_b = '0;
    logic        m_sgn = 1'b0, m_busy = 1'b0, m_done = 1'b0;
    logic [63:0] m_prod = '0;
    int          m_left = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_a = '0; m_b = '0; m_sgn = 1'b0; m_busy = 1'b0;
            m_done = 1'b0; m_prod = '0; m_left = 0;
        end else begin
            logic was_busy;
            was_busy = m_busy;
            if (en && !we && addr == 3'd3) m_done = 1'b0;
            if (m_busy) begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    if (m_sgn) m_prod = longint'($signed(m_a)) * longint'($signed(m_b));
                    else       m_prod = {32'd0, m_a} * {32'd0, m_b};
                    m_busy = 1'b0;
                    m_done = 1'b1;
                end
            end
            if (!was_busy && en && we) begin
                case (addr)
                    3'd0: m_a = wd;
                    3'd1: begin m_b = wd; m_busy = 1'b1; m_left = 3; m_done = 1'b0; end
                    3'd4: m_sgn = wd[0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return m_a;
            3'd1: return m_b;
            3'd2: return m_prod[31:0];
            3'd3: return m_prod[63:32];
            3'd4: return {29'd0, m_done, m_busy, m_sgn};
            default: return 32'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // One bus cycle: compare against the model, then drive new inputs.
    task automatic step(input logic e, input logic w, input logic [2:0] a, input logic [31:0] d);
        string tag;
        @(negedge clk);
        case (addr)
            3'd0, 3'd1: tag = "R2 readback";
            3'd2, 3'd3: tag = "R4/R5 product";
            3'd4:       tag = "R3/R7 status";
            default:    tag = "R8 reserved";
        endcase
        if (!rst) chk(tag, rdata, model_read(addr));
        en = e; we = w; addr = a; wd = d;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        step(1'b1, 1'b1, a, d);
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        step(1'b1, 1'b0, a, 32'd0);
        #1 v = rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 3'd7, 32'd0);
    endtask

    task automatic mul(input logic s, input logic [31:0] a, input logic [31:0] b,
                       output logic [31:0] lo, output logic [31:0] hi);
        wr(3'd4, {31'd0, s});
        wr(3'd0, a);
        wr(3'd1, b);
        idle(4);
        rd(3'd2, lo);
        rd(3'd3, hi);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : stim
        logic [31:0] v, lo, hi;
        logic [63:0] e64;
        idle(3);
        @(negedge clk); rst = 1'b0;

        // R1 reset values
        for (int k = 0; k < 5; k++) begin
            rd(3'(k), v);
            chk("R1 reset value", v, 32'd0);
        end

        // R2 factor storage
        wr(3'd0, 32'h1234_5678);
        rd(3'd0, v); chk("R2 factor A", v, 32'h1234_5678);

        // R3 busy window, R7 done rising
        wr(3'd1, 32'h9abc_def0);
        rd(3'd4, v); chk("R3 busy cycle 1", v, 32'h2);
        rd(3'd4, v); chk("R3 busy cycle 2", v, 32'h2);
        rd(3'd4, v); chk("R3 busy cycle 3", v, 32'h2);
        rd(3'd4, v); chk("R3/R7 idle with done", v, 32'h4);
        e64 = 64'h1234_5678 * 64'h9abc_def0;
        rd(3'd2, v); chk("R4 unsigned low", v, e64[31:0]);
        rd(3'd4, v); chk("R7 done kept after low read", v, 32'h4);
        rd(3'd3, v); chk("R4 unsigned high", v, e64[63:32]);
        rd(3'd4, v); chk("R7 done cleared by high read", v, 32'h0);

        // R4 unsigned corner
        mul(1'b0, 32'hffff_ffff, 32'hffff_ffff, lo, hi);
        chk("R4 max low", lo, 32'h0000_0001);
        chk("R4 max high", hi, 32'hffff_fffe);

        // R5 signed corners
        mul(1'b1, 32'hffff_ffff, 32'hffff_ffff, lo, hi);
        chk("R5 -1*-1 low", lo, 32'h1); chk("R5 -1*-1 high", hi, 32'h0);
        mul(1'b1, 32'h8000_0000, 32'h8000_0000, lo, hi);
        chk("R5 min*min low", lo, 32'h0); chk("R5 min*min high", hi, 32'h4000_0000);
        mul(1'b1, 32'hffff_fffe, 32'h3, lo, hi);
        chk("R5 -2*3 low", lo, 32'hffff_fffa); chk("R5 -2*3 high", hi, 32'hffff_ffff);
        mul(1'b1, 32'h7fff_ffff, 32'h8000_0000, lo, hi);
        chk("R5 max*min low", lo, 32'h8000_0000); chk("R5 max*min high", hi, 32'hc000_0000);

        // R6 writes while busy ignored
        mul(1'b0, 32'd7, 32'd6, lo, hi);
        wr(3'd1, 32'd5);
        wr(3'd0, 32'd100);
        wr(3'd1, 32'd200);
        wr(3'd4, 32'd1);
        rd(3'd4, v); chk("R6 no restart, idle after window", v, 32'h4);
        rd(3'd0, v); chk("R6 factor A kept", v, 32'd7);
        rd(3'd1, v); chk("R6 factor B kept", v, 32'd5);
        rd(3'd2, v); chk("R6 product of accepted factors", v, 32'd35);

        // R8 read-only and reserved offsets
        wr(3'd2, 32'hdead_beef);
        wr(3'd3, 32'hdead_beef);
        wr(3'd5, 32'hffff_ffff);
        rd(3'd2, v); chk("R8 low not writable", v, 32'd35);
        rd(3'd3, v); chk("R8 high not writable", v, 32'd0);
        rd(3'd6, v); chk("R8 reserved reads zero", v, 32'd0);
        rd(3'd4, v); chk("R8 status unchanged", v, 32'h0);

        // R9 product holds across idle and factor writes
        wr(3'd0, 32'h55);
        idle(6);
        rd(3'd2, v); chk("R9 product held", v, 32'd35);

        // R7 start clears done
        mul(1'b0, 32'd3, 32'd3, lo, hi);
        wr(3'd1, 32'd4);
        rd(3'd4, v); chk("R7 done cleared by start", v, 32'h2);
        idle(4);

        // Mixed random traffic, compared each cycle against the model
        for (int n = 0; n < 3000; n++) begin
            logic [2:0] ra;
            ra = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 2) == 0) step(1'b1, 1'b0, ra, 32'd0);
            else if ($urandom_range(0, 1) == 0) step(1'b1, 1'b1, ra, $urandom());
            else step(1'b1, 1'b1, 3'($urandom_range(0, 1) * 4), $urandom());
        end
        idle(5);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule